// File: doc/BRIEF.md
# Power-of-Two Exponent Scaler for Double-Precision Coefficients

This block multiplies a 64-bit IEEE-754 double-precision value by a power of two. It does this by adding a signed shift to the 11-bit exponent field. No multiplier or rounding logic is involved. A typical use is pre-scaling filter coefficients before a sample-format conversion. A shift of +31 suits float-to-integer paths, and shifts of -15, -19, -23 or -31 suit 16-, 20-, 24- and 32-bit integer-to-float paths.

Zero and denormal encodings (exponent field all zeros) pass through untouched. So do infinity and NaN encodings (exponent field all ones). When the shifted exponent would leave the normal range, the block does not saturate. It returns the input word unchanged and raises an error flag on that result. Every accepted input yields exactly one result, one clock later.

Top module: `fp64_pow2_scaler`

## Requirements
- R1: Bit 63 (sign) and bits 51:0 (fraction) of every result equal the same bits of the input that produced it.
- R2: An input whose exponent field (bits 62:52) is 0 or 0x7FF is returned unchanged, with the error flag low.
- R3: For any other input, the result exponent equals the input exponent plus the shift, where the shift is read as an 8-bit two's-complement number.
- R4: With a shift greater than zero, a sum of 0x7FF or more is an error.
- R5: With a shift less than zero, a sum of 0 or less is an error.
- R6: On an error, the result word equals the input word. The error flag is high only in a cycle where the output valid is high.
- R7: The output valid is high exactly one cycle after the input valid was sampled high. When no new input is taken, the result word keeps its last value.
- R8: While reset is held, and until the first input is accepted, the output valid and the error flag are low.
- R9: A shift of zero returns the input unchanged, with no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Input word and shift are present this cycle |
| in_value | input | 64 | Double-precision input word |
| in_shift | input | 8 | Signed power-of-two exponent to apply |
| out_valid | output | 1 | Result is present this cycle |
| out_value | output | 64 | Scaled word, or the input word on error |
| out_error | output | 1 | Shifted exponent left the normal range |

## Verification
The conversion shifts (+31, -15, -19, -23, -31) are applied to ordinary normal values. These show that only the exponent moves. Values sitting exactly on the range edges (exponents 0x7FE, 0x7F0, 0x80, 0x81, 1 and 2), combined with shifts of +127, -128, +-1, +14 and +15, separate a correct bound from one that is off by one in either direction. Zeros, denormals, infinities and NaNs are sent with large shifts. These show that the special encodings bypass the adder and never raise an error. Bubbles in the input valid, and a long run of random words and shifts, exercise holding the value and the one-cycle timing.

// File: rtl/fp_scale_pkg.sv
package fp_scale_pkg;
  typedef enum logic [1:0] {
    SCL_BYPASS = 2'd0,
    SCL_SCALED = 2'd1,
    SCL_OVER   = 2'd2,
    SCL_UNDER  = 2'd3
  } scl_kind_e;
endpackage

// File: rtl/fp_scale_rst_sync.sv
module fp_scale_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fp_scale_classify.sv
module fp_scale_classify #(
  parameter int WORD_W = 64,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [WORD_W-1:0] word,
  output logic [EXP_W-1:0]  exp_field,
  output logic              is_special
);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

  logic [FRAC_W-1:0] frac_unused;
  logic              sign_unused;

  assign {sign_unused, exp_field, frac_unused} = word;
  assign is_special = (exp_field == '0) || (exp_field == EXP_ONES);
endmodule

// File: rtl/fp_scale_adjust.sv
module fp_scale_adjust
  import fp_scale_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int SHIFT_W = 8
) (
  input  logic [EXP_W-1:0]   exp_in,
  input  logic               special,
  input  logic [SHIFT_W-1:0] shift,
  output logic [EXP_W-1:0]   exp_out,
  output scl_kind_e          kind
);
  localparam int SUM_W = ((EXP_W > SHIFT_W) ? EXP_W : SHIFT_W) + 2;
  localparam logic signed [SUM_W-1:0] EXP_TOP = SUM_W'((1 << EXP_W) - 1);

  logic signed [SUM_W-1:0] exp_ext;
  logic signed [SUM_W-1:0] shift_ext;
  logic signed [SUM_W-1:0] sum;
  logic                    shift_pos;
  logic                    shift_neg;

  always_comb begin
    exp_ext   = $signed({{(SUM_W-EXP_W){1'b0}}, exp_in});
    shift_ext = $signed({{(SUM_W-SHIFT_W){shift[SHIFT_W-1]}}, shift});
    sum       = exp_ext + shift_ext;
    shift_neg = shift[SHIFT_W-1];
    shift_pos = !shift_neg && (shift != '0);
    exp_out   = sum[EXP_W-1:0];
    if (special)                         kind = SCL_BYPASS;
    else if (shift_pos && sum >= EXP_TOP) kind = SCL_OVER;
    else if (shift_neg && sum <= 0)       kind = SCL_UNDER;
    else                                  kind = SCL_SCALED;
  end
endmodule

// File: rtl/fp64_pow2_scaler.sv
module fp64_pow2_scaler
  import fp_scale_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int EXP_W   = 11,
  parameter int SHIFT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_value,
  input  logic [SHIFT_W-1:0] in_shift,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_value,
  output logic              out_error
);
  localparam int FRAC_W  = WORD_W - EXP_W - 1;
  localparam int EXP_LSB = FRAC_W;
  localparam int EXP_MSB = FRAC_W + EXP_W - 1;

  logic             rst_sync_n;
  logic [EXP_W-1:0] exp_field;
  logic             is_special;
  logic [EXP_W-1:0] exp_new;
  scl_kind_e        kind;

  logic              valid_d, valid_q;
  logic              err_d, err_q;
  logic [WORD_W-1:0] value_d, value_q;
  logic              value_en;

  fp_scale_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fp_scale_classify #(.WORD_W(WORD_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .word(in_value), .exp_field(exp_field), .is_special(is_special)
  );

  fp_scale_adjust #(.EXP_W(EXP_W), .SHIFT_W(SHIFT_W)) u_adjust (
    .exp_in(exp_field), .special(is_special), .shift(in_shift),
    .exp_out(exp_new), .kind(kind)
  );

  always_comb begin
    valid_d  = in_valid;
    value_en = in_valid;
    err_d    = in_valid && (kind == SCL_OVER || kind == SCL_UNDER);
    value_d  = in_value;
    if (kind == SCL_SCALED) value_d[EXP_MSB:EXP_LSB] = exp_new;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (value_en) value_q <= value_d;
  end

  assign out_valid = valid_q;
  assign out_error = err_q;
  assign out_value = value_q;
endmodule

// File: rtl/fp64_pow2_scaler_chk.sv
module fp64_pow2_scaler_chk #(
  parameter int WORD_W  = 64,
  parameter int EXP_W   = 11,
  parameter int SHIFT_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_value,
  input logic [SHIFT_W-1:0] in_shift,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_value,
  input logic              out_error
);
  localparam int FRAC_W  = WORD_W - EXP_W - 1;
  localparam logic [WORD_W-1:0] KEEP_MASK =
    {1'b1, {EXP_W{1'b0}}, {FRAC_W{1'b1}}};
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

  logic in_special;
  assign in_special = (in_value[WORD_W-2 -: EXP_W] == '0) ||
                      (in_value[WORD_W-2 -: EXP_W] == EXP_ONES);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  a_r7_value_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_value));
  a_r6_err_with_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_error |-> out_valid);
  a_r1_fields_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> ((out_value & KEEP_MASK) == ($past(in_value) & KEEP_MASK)));
  a_r2_special_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_special) |=> (out_value == $past(in_value) && !out_error));
  a_r6_err_keeps_word: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_error |-> (out_value == $past(in_value)));
  a_r9_zero_shift: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_shift == '0) |=> (out_value == $past(in_value) && !out_error));
endmodule

bind fp64_pow2_scaler fp64_pow2_scaler_chk #(
  .WORD_W(WORD_W), .EXP_W(EXP_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid), .in_value(in_value),
  .in_shift(in_shift), .out_valid(out_valid), .out_value(out_value),
  .out_error(out_error)
);

// File: tb/fp64_pow2_scaler_bench.sv
module fp64_pow2_scaler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_value = '0;
  logic [7:0]  in_shift = '0;
  logic        out_valid;
  logic [63:0] out_value;
  logic        out_error;

  int n_checks = 0;
  int n_fail   = 0;

  logic        exp_pending = 1'b0;
  logic [63:0] exp_word;
  logic        exp_err;
  string       exp_tag;
  logic        have_last = 1'b0;
  logic [63:0] last_word;
  logic [63:0] src_word;

  always #5 clk = ~clk;

  fp64_pow2_scaler u_fp64_pow2_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_shift(in_shift), .out_valid(out_valid), .out_value(out_value),
    .out_error(out_error)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model(input logic [63:0] v, input logic [7:0] s,
                       output logic [63:0] w, output logic e, output string tag);
    int ex, sh, n;
    ex = int'(v[62:52]);
    sh = int'($signed(s));
    w = v; e = 1'b0;
    if (ex == 0 || ex == 2047) begin
      tag = "R2";
    end else if (sh == 0) begin
      tag = "R9";
    end else begin
      n = ex + sh;
      if (sh > 0 && n >= 2047) begin e = 1'b1; tag = "R4"; end
      else if (sh < 0 && n <= 0) begin e = 1'b1; tag = "R5"; end
      else begin w[62:52] = n[10:0]; tag = "R3"; end
    end
  endtask

  // Compare the outputs of the previous cycle, then apply the next input.
  task automatic step(input logic v, input logic [63:0] word, input logic [7:0] s);
    @(negedge clk);
    check(out_valid == exp_pending, "R7 valid", {63'd0, out_valid}, {63'd0, exp_pending});
    if (exp_pending) begin
      check(out_value == exp_word, exp_tag, out_value, exp_word);
      check(out_error == exp_err, {exp_tag, " error"}, {63'd0, out_error}, {63'd0, exp_err});
      check((out_value & 64'h800F_FFFF_FFFF_FFFF) == (src_word & 64'h800F_FFFF_FFFF_FFFF),
            "R1", out_value, src_word);
      if (exp_err) check(out_value == src_word, "R6", out_value, src_word);
      last_word = out_value; have_last = 1'b1;
    end else begin
      check(out_error == 1'b0, "R6 idle error", {63'd0, out_error}, 64'd0);
      if (have_last) check(out_value == last_word, "R7 hold", out_value, last_word);
    end
    in_valid = v; in_value = word; in_shift = s;
    exp_pending = v;
    if (v) begin
      src_word = word;
      model(word, s, exp_word, exp_err, exp_tag);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_error == 1'b0, "R8 reset", {62'd0, out_valid, out_error}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_error == 1'b0, "R8 after release",
          {62'd0, out_valid, out_error}, 64'd0);
    // conversion shifts on 1.0 and -3.5
    step(1, 64'h3FF0_0000_0000_0000, 8'd31);
    step(1, 64'h3FF0_0000_0000_0000, -8'sd15);
    step(1, 64'hC00C_0000_0000_0000, -8'sd19);
    step(1, 64'hC00C_0000_0000_0000, -8'sd23);
    step(1, 64'h41DF_FFFF_FFC0_0000, -8'sd31);
    step(0, '0, '0);
    step(0, '0, '0);
    // special encodings
    step(1, 64'h0000_0000_0000_0000, 8'd127);
    step(1, 64'h8000_0000_0000_0000, -8'sd128);
    step(1, 64'h0000_0000_0000_0001, 8'd31);
    step(1, 64'h7FF0_0000_0000_0000, -8'sd31);
    step(1, 64'hFFF8_0000_0000_0001, 8'd1);
    // range edges
    step(1, 64'h7FE0_0000_0000_0005, 8'd1);
    step(1, 64'h7F00_0000_0000_0000, 8'd14);
    step(1, 64'h7F00_0000_0000_0000, 8'd15);
    step(1, 64'h0010_0000_0000_0000, -8'sd1);
    step(1, 64'h0020_0000_0000_0000, -8'sd1);
    step(1, 64'h0800_0000_0000_0000, -8'sd128);
    step(1, 64'h0810_0000_0000_0000, -8'sd128);
    step(1, 64'h7800_0000_0000_0000, 8'd127);
    step(1, 64'h7810_0000_0000_0000, 8'd127);
    step(1, 64'h7FE0_0000_0000_0000, 8'd0);
    step(0, '0, '0);
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      if (i % 7 == 0) w[62:52] = (i % 2 == 0) ? 11'h7FF : 11'h000;
      if (i % 5 == 0) w[62:52] = 11'h7FE - 11'(i % 40);
      step(($urandom % 4) != 0, w, 8'($urandom));
    end
    step(0, '0, '0);
    step(0, '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule